// File: doc/BRIEF.md
# Power and Thermal Fault Monitor

This block supervises the supply and temperature health of a board-level system. It watches seven power-good lines and three temperature readings: processor core, graphics core and embedded memory. Each reading is compared with its own trip threshold. The block also watches two error flags from the management bus, one for the temperature sensor device and one for the clock device. When a fault appears, the block sorts it into one of two classes, fatal or thermal, and latches an 8-bit error code. It also presents that code as four base-4 digits for a front-panel display.

Supervision runs only while the enable input is high. This lets the sequencer hold the monitor off while rails ramp. Only the first fault is kept, and later faults cannot overwrite it. A synchronous clear or a reset re-arms the monitor. If several faults are detected in the same cycle, a fixed priority decides which code is stored. The power-good lines are asynchronous to the block clock, so they pass through a two-flop synchronizer before they are judged. All other inputs are taken as synchronous.

Top module: `pwr_fault_mon`

## Requirements
- R1: After reset, `code_o` is 0, `fatal_o` and `thermal_o` are low, and `digits_o` is 0.
- R2: A low power-good line raises `fatal_o` with a code fixed by the line index: bit 0 gives 0x01, bit 1 gives 0x02, bit 2 gives 0x03, bit 3 gives 0x0B, bit 4 gives 0x0D, bit 5 gives 0x0E, bit 6 gives 0x0F.
- R3: A power-good line goes through a two-flop synchronizer. A line driven low before clock edge 1 is not visible on the outputs after edge 2 and is visible after edge 3.
- R4: While `temp_vld_i` is high, a temperature strictly above its trip value raises `thermal_o` one edge later. The codes are 0x05 for processor, 0x06 for graphics and 0x07 for embedded memory. A temperature equal to the trip value is not a fault. Nothing is judged while `temp_vld_i` is low.
- R5: `sens_err_i` raises `fatal_o` with code 0x04. `clkdev_err_i` raises `fatal_o` with code 0x0B.
- R6: While `temp_vld_i` is high, a read in which all three temperatures are zero raises `fatal_o` with code 0x0C.
- R7: Once a code is latched, it and its class flag stay unchanged until a clear or a reset, whatever faults follow.
- R8: `clr_i` high at a clock edge returns the outputs to the reset state at that edge. A fault present in the same cycle is not latched.
- R9: While `en_i` is low, no fault is latched.
- R10: When faults are present in the same cycle, any fatal code beats any thermal code. Within a class, the numerically lowest code wins.
- R11: `digits_o` carries four digits of 4 bits each, with the most significant digit in bits 15:12. Digit k (bits 4k+3:4k) equals code bits 2k+1:2k. For example, code 0x05 shows as 16'h0011 and code 0x0C shows as 16'h0030.
- R12: `fatal_o` and `thermal_o` are never high together, and `code_o` is non-zero exactly when one of them is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Monitoring enable |
| clr_i | input | 1 | Synchronous clear of the latched fault |
| pg_i | input | 7 | Power-good lines, high means the rail is in tolerance |
| temp_cpu_i | input | TEMP_W | Processor temperature reading |
| temp_gpu_i | input | TEMP_W | Graphics temperature reading |
| temp_edram_i | input | TEMP_W | Embedded memory temperature reading |
| trip_cpu_i | input | TEMP_W | Processor trip threshold |
| trip_gpu_i | input | TEMP_W | Graphics trip threshold |
| trip_edram_i | input | TEMP_W | Embedded memory trip threshold |
| temp_vld_i | input | 1 | Temperature readings are valid this cycle |
| sens_err_i | input | 1 | Sensor device stopped answering on the management bus |
| clkdev_err_i | input | 1 | Clock device stopped answering on the management bus |
| fatal_o | output | 1 | Latched fault is of the fatal class |
| thermal_o | output | 1 | Latched fault is of the thermal class |
| code_o | output | 8 | Latched error code, 0 when none |
| digits_o | output | 16 | Four base-4 display digits, one per nibble |

## Verification
Rail faults arrive through the synchronizer two cycles late, while sensor, bus and temperature faults arrive at once. Any two or more of them can therefore collide at the latch edge, but only if their timing is aligned. The bench aligns them by holding enable low while every combination of the twelve fault sources is applied. It then raises enable for exactly the edge on which the synchronized rails become visible. Each of the 4096 outcomes is judged against a minimum computed in the bench over the fatal codes, falling back to the thermal codes when no fatal fault is present.

// File: rtl/pwr_fault_pkg.sv
package pwr_fault_pkg;
  localparam int CODE_W     = 8;
  localparam int NUM_RAILS  = 7;
  localparam int NUM_TEMPS  = 3;
  localparam int NUM_CODES  = 16;
  localparam int NUM_DIGITS = CODE_W / 2;
  localparam int THERM_LO   = 5;
  localparam int THERM_HI   = THERM_LO + NUM_TEMPS - 1;
  localparam int CODE_SENSOR_LOST = 4;
  localparam int CODE_CLKDEV_LOST = 11;
  localparam int CODE_TEMP_ZERO   = 12;

  function automatic int rail_code(int idx);
    case (idx)
      0: return 1;
      1: return 2;
      2: return 3;
      3: return 11;
      4: return 13;
      5: return 14;
      default: return 15;
    endcase
  endfunction

  function automatic logic is_thermal(int c);
    return (c >= THERM_LO) && (c <= THERM_HI);
  endfunction
endpackage

// File: rtl/pfm_pg_sync.sv
module pfm_pg_sync #(
  parameter int W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  // reset to "good" so a cold start raises nothing
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '1;
      s2_q <= '1;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/pfm_detect.sv
module pfm_detect
  import pwr_fault_pkg::*;
#(
  parameter int TEMP_W = 8
) (
  input  logic                             en_i,
  input  logic [NUM_RAILS-1:0]             pg_s_i,
  input  logic [NUM_TEMPS-1:0][TEMP_W-1:0] temp_i,
  input  logic [NUM_TEMPS-1:0][TEMP_W-1:0] trip_i,
  input  logic                             temp_vld_i,
  input  logic                             sens_err_i,
  input  logic                             clkdev_err_i,
  output logic [NUM_CODES-1:0]             req_o
);
  logic [NUM_TEMPS-1:0] over;
  logic                 all_zero;

  for (genvar t = 0; t < NUM_TEMPS; t++) begin : g_cmp
    assign over[t] = temp_i[t] > trip_i[t];
  end

  assign all_zero = ~|temp_i;

  always_comb begin
    req_o = '0;
    if (en_i) begin
      for (int r = 0; r < NUM_RAILS; r++)
        if (!pg_s_i[r]) req_o[rail_code(r)] = 1'b1;
      if (temp_vld_i) begin
        for (int t = 0; t < NUM_TEMPS; t++)
          if (over[t]) req_o[THERM_LO + t] = 1'b1;
        if (all_zero) req_o[CODE_TEMP_ZERO] = 1'b1;
      end
      if (sens_err_i)   req_o[CODE_SENSOR_LOST] = 1'b1;
      if (clkdev_err_i) req_o[CODE_CLKDEV_LOST] = 1'b1;
    end
  end
endmodule

// File: rtl/pfm_pick.sv
module pfm_pick
  import pwr_fault_pkg::*;
(
  input  logic [NUM_CODES-1:0] req_i,
  output logic                 hit_o,
  output logic [CODE_W-1:0]    code_o,
  output logic                 fatal_o
);
  // descending scans: lowest code is written last; fatal pass overrides thermal
  always_comb begin
    hit_o   = 1'b0;
    code_o  = '0;
    fatal_o = 1'b0;
    for (int i = NUM_CODES - 1; i >= 0; i--)
      if (req_i[i] && is_thermal(i)) begin
        hit_o   = 1'b1;
        code_o  = CODE_W'(i);
        fatal_o = 1'b0;
      end
    for (int i = NUM_CODES - 1; i >= 0; i--)
      if (req_i[i] && !is_thermal(i)) begin
        hit_o   = 1'b1;
        code_o  = CODE_W'(i);
        fatal_o = 1'b1;
      end
  end
endmodule

// File: rtl/pwr_fault_mon.sv
module pwr_fault_mon
  import pwr_fault_pkg::*;
#(
  parameter int TEMP_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    clr_i,
  input  logic [NUM_RAILS-1:0]    pg_i,
  input  logic [TEMP_W-1:0]       temp_cpu_i,
  input  logic [TEMP_W-1:0]       temp_gpu_i,
  input  logic [TEMP_W-1:0]       temp_edram_i,
  input  logic [TEMP_W-1:0]       trip_cpu_i,
  input  logic [TEMP_W-1:0]       trip_gpu_i,
  input  logic [TEMP_W-1:0]       trip_edram_i,
  input  logic                    temp_vld_i,
  input  logic                    sens_err_i,
  input  logic                    clkdev_err_i,
  output logic                    fatal_o,
  output logic                    thermal_o,
  output logic [CODE_W-1:0]       code_o,
  output logic [4*NUM_DIGITS-1:0] digits_o
);
  logic [NUM_RAILS-1:0]             pg_s;
  logic [NUM_TEMPS-1:0][TEMP_W-1:0] temps, trips;
  logic [NUM_CODES-1:0]             req;
  logic                             hit, hit_fatal;
  logic [CODE_W-1:0]                hit_code;
  logic                             held_q, fatal_q;
  logic [CODE_W-1:0]                code_q;

  assign temps = {temp_edram_i, temp_gpu_i, temp_cpu_i};
  assign trips = {trip_edram_i, trip_gpu_i, trip_cpu_i};

  pfm_pg_sync #(.W(NUM_RAILS)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pg_i),
    .q_o    (pg_s)
  );

  pfm_detect #(.TEMP_W(TEMP_W)) i_detect (
    .en_i         (en_i),
    .pg_s_i       (pg_s),
    .temp_i       (temps),
    .trip_i       (trips),
    .temp_vld_i   (temp_vld_i),
    .sens_err_i   (sens_err_i),
    .clkdev_err_i (clkdev_err_i),
    .req_o        (req)
  );

  pfm_pick i_pick (
    .req_i   (req),
    .hit_o   (hit),
    .code_o  (hit_code),
    .fatal_o (hit_fatal)
  );

  // first-fault latch; clear wins over a same-cycle fault
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q  <= 1'b0;
      fatal_q <= 1'b0;
      code_q  <= '0;
    end else if (clr_i) begin
      held_q  <= 1'b0;
      fatal_q <= 1'b0;
      code_q  <= '0;
    end else if (!held_q && hit) begin
      held_q  <= 1'b1;
      fatal_q <= hit_fatal;
      code_q  <= hit_code;
    end
  end

  assign fatal_o   = held_q & fatal_q;
  assign thermal_o = held_q & ~fatal_q;
  assign code_o    = code_q;

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_digit
    assign digits_o[4*k +: 4] = {2'b00, code_q[2*k +: 2]};
  end
endmodule

// File: rtl/pwr_fault_mon_chk.sv
module pwr_fault_mon_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic       clr_i,
  input logic       fatal_o,
  input logic       thermal_o,
  input logic [7:0] code_o
);
  // R12
  excl_class_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fatal_o && thermal_o));

  // R12
  code_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_o != 8'd0) |-> (fatal_o || thermal_o));

  // R7
  hold_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_o != 8'd0 && !clr_i) |=> ($stable(code_o) && $stable(fatal_o)));

  // R8
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (code_o == 8'd0 && !fatal_o && !thermal_o));

  // R9
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && code_o == 8'd0) |=> (code_o == 8'd0));

  // R4
  thermal_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thermal_o |-> (code_o >= 8'd5 && code_o <= 8'd7));
endmodule

bind pwr_fault_mon pwr_fault_mon_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .clr_i     (clr_i),
  .fatal_o   (fatal_o),
  .thermal_o (thermal_o),
  .code_o    (code_o)
);

// File: tb/test_pwr_fault_mon.sv
module test_pwr_fault_mon;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [7:0] TRIP = 8'd100;
  localparam logic [7:0] NORM = 8'd50;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, clr = 1'b0;
  logic [6:0] pg = '1;
  logic [7:0] t_cpu = NORM, t_gpu = NORM, t_edr = NORM;
  logic       tvld = 1'b1, sens_err = 1'b0, clk_err = 1'b0;
  logic       fatal, thermal;
  logic [7:0] code;
  logic [15:0] digits;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_fault_mon i_pwr_fault_mon (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .clr_i(clr), .pg_i(pg),
    .temp_cpu_i(t_cpu), .temp_gpu_i(t_gpu), .temp_edram_i(t_edr),
    .trip_cpu_i(TRIP), .trip_gpu_i(TRIP), .trip_edram_i(TRIP),
    .temp_vld_i(tvld), .sens_err_i(sens_err), .clkdev_err_i(clk_err),
    .fatal_o(fatal), .thermal_o(thermal), .code_o(code), .digits_o(digits)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_digits(int c);
    logic [15:0] d = '0;
    int p = 1;
    for (int k = 0; k < 4; k++) begin
      d = d | 16'(((c / p) % 4) << (4 * k));
      p = p * 4;
    end
    return d;
  endfunction

  task automatic check_out(string req, int c);
    logic th = (c >= 5 && c <= 7);
    check({req, " code"}, 32'(code), 32'(c));
    check({req, " fatal"}, 32'(fatal), 32'(c != 0 && !th));
    check({req, " thermal"}, 32'(thermal), 32'(th));
    check({req, " R11 digits"}, 32'(digits), 32'(exp_digits(c)));
  endtask

  function automatic int src_code(int i);
    case (i)
      0: return 1;  1: return 2;  2: return 3;  3: return 11;
      4: return 13; 5: return 14; 6: return 15;
      7: return 5;  8: return 6;  9: return 7;
      10: return 4; default: return 11;
    endcase
  endfunction

  function automatic int exp_of(logic [11:0] m);
    int bf = 999, bt = 999;
    for (int i = 0; i < 12; i++)
      if (m[i]) begin
        int c = src_code(i);
        if (c >= 5 && c <= 7) begin if (c < bt) bt = c; end
        else if (c < bf) bf = c;
      end
    if (bf != 999) return bf;
    if (bt != 999) return bt;
    return 0;
  endfunction

  task automatic set_sources(logic [11:0] m);
    pg       = ~m[6:0];
    t_cpu    = m[7] ? TRIP + 8'd1 : NORM;
    t_gpu    = m[8] ? TRIP + 8'd1 : NORM;
    t_edr    = m[9] ? TRIP + 8'd1 : NORM;
    sens_err = m[10];
    clk_err  = m[11];
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic flush();
    @(negedge clk);
    set_sources('0);
    tvld = 1'b1;
    en = 1'b0;
    clr = 1'b1;
    tick(1);
    clr = 1'b0;
    tick(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk);
    check_out("R1 in reset", 0);
    rst_n = 1'b1;
    tick(1);
    check_out("R1 after reset", 0);

    // R3 synchronizer latency
    flush();
    en = 1'b1;
    pg[1] = 1'b0;
    tick(1);
    check_out("R3 edge1", 0);
    tick(1);
    check_out("R3 edge2", 0);
    tick(1);
    check_out("R3 R2 edge3", 2);

    // R4 equal-to-trip and valid gating
    flush();
    en = 1'b1;
    t_gpu = TRIP;
    tick(1);
    check_out("R4 equal trip", 0);
    tvld = 1'b0;
    t_gpu = TRIP + 8'd1;
    tick(2);
    check_out("R4 vld low", 0);
    tvld = 1'b1;
    tick(1);
    check_out("R4 gpu over", 6);

    // R7 later faults ignored
    sens_err = 1'b1;
    pg[0] = 1'b0;
    tick(4);
    check_out("R7 first kept", 6);
    pg = '1;
    sens_err = 1'b0;
    t_gpu = NORM;
    tick(2);
    check_out("R7 still kept", 6);

    // R8 clear beats a same-cycle fault
    clr = 1'b1;
    sens_err = 1'b1;
    tick(1);
    check_out("R8 clear wins", 0);
    clr = 1'b0;
    tick(1);
    check_out("R8 R5 relatch", 4);

    // R6 all-zero read
    flush();
    en = 1'b1;
    t_cpu = '0; t_gpu = '0; t_edr = '0;
    tvld = 1'b0;
    tick(1);
    check_out("R6 zero vld low", 0);
    tvld = 1'b1;
    tick(1);
    check_out("R6 zero read", 12);

    // R2 R4 R5 R9 R10 exhaustive over all source combinations
    for (int m = 0; m < 4096; m++) begin
      flush();
      set_sources(12'(m));
      tick(2);
      check("R9 disabled", 32'(code), 32'd0);
      en = 1'b1;
      tick(1);
      check_out("R2 R4 R5 R10 sweep", exp_of(12'(m)));
      en = 1'b0;
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule